// File: doc/BRIEF.md
# Overload and thermal protection sequencer

This block decides when the supply output stage of a low-noise-block feed may drive the cable. It watches two fault levels, an overload level from the current sensing and an overtemperature level from the thermal sensing, and it counts a 1 ms tick. Its output enable gates the output stage. Its one-cycle strobes tell the surrounding register block to set the overload or overtemperature flag, or to clear the whole voltage-select field.

An overload is handled in one of two ways. In static mode it is only reported, and the output keeps running. In dynamic mode the output stays on for an on window and then goes dark for an off window. On and off windows alternate for as long as overload is seen inside the on windows. One full on window without overload ends the cycling. An overtemperature event overrides all of this and keeps the output dark until it clears. For both fault kinds a configuration bit chooses the recovery. Either the output returns by itself, or the voltage-select field is cleared and the output waits for the host to program it again.

The fault levels pass through a parameterised synchroniser first. All window lengths are parameters counted in ticks: 90 and 180 for the two on-window choices and 900 for the off window by default.

Top module: `olp_seq`

## Requirements
- R1: During and after reset the strobes are low, and the sequencer is idle: `out_en_o` follows `vsel_nz_i` (high means the voltage-select field is nonzero).
- R2: While `vsel_nz_i` is low (standby), `out_en_o` is low and an overload starts no cycling and raises no strobe; raising `vsel_nz_i` with no overload present enables the output in the next cycle.
- R3: With `pulse_static_i`=1 (static mode), an overload leaves `out_en_o` high and only produces an overload strobe.
- R4: With `pulse_static_i`=0 (dynamic mode), once an overload is seen the output stays high for an on window of ON_SHORT_MS ticks (`long_on_i`=0) or ON_LONG_MS ticks (`long_on_i`=1), and then stays low for exactly OFF_MS ticks.
- R5: After each off window the output gets a full on window. If overload is seen at any time inside that window, another off window follows, and this repeats.
- R6: An on window with no overload and `ovl_latch_i`=0 returns the block to normal operation with the output enabled.
- R7: An on window with no overload and `ovl_latch_i`=1 gives a one-cycle `vsel_clr_o`. The output then stays low until `vsel_nz_i` has gone low and been raised again.
- R8: Overtemperature drives the output low from the cycle after the synchronised level rises, and it takes priority over overload cycling. The window timers are discarded, so recovery does not wait for an unfinished off window. Each rising edge gives exactly one `ovt_set_o` strobe.
- R9: When overtemperature clears, `thm_latch_i`=0 re-enables the output at once, and `thm_latch_i`=1 gives the `vsel_clr_o` strobe and hold of R7.
- R10: `ovl_set_o` gives one single-cycle strobe each time an overload becomes visible while the output is enabled.
- R11: Both fault levels pass through SYNC_STAGES flops. With the default of 2, `out_en_o` is still high two clock edges after overtemperature rises and low after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| ovl_i | input | 1 | Overload level (asynchronous) |
| ovt_i | input | 1 | Overtemperature level (asynchronous) |
| vsel_nz_i | input | 1 | High when the voltage-select field is nonzero |
| pulse_static_i | input | 1 | 1 = static overload handling, 0 = dynamic |
| long_on_i | input | 1 | 1 = long on window, 0 = short |
| ovl_latch_i | input | 1 | 1 = clear voltage select after overload recovery |
| thm_latch_i | input | 1 | 1 = clear voltage select after thermal recovery |
| out_en_o | output | 1 | Output stage enable |
| vsel_clr_o | output | 1 | Strobe: clear all voltage-select bits |
| ovl_set_o | output | 1 | Strobe: set overload flag |
| ovt_set_o | output | 1 | Strobe: set overtemperature flag |

## Verification
A table of overload bursts is replayed with bursts of different lengths. A burst that ends inside the first on window and one that ends inside an off window must both give a single off window. A burst that reaches into the second or third on window must give two or three off windows. Running the same bursts with each window-length setting separates the 6- and 12-tick on windows, and running them with each recovery bit separates self-resume from the hold that waits for a host rewrite. Directed cases cover the standby case, repeated static overloads and the synchroniser latency of overtemperature. One case raises overtemperature in the middle of an off window, which shows that the thermal path discards the overload timers.

// File: rtl/olp_pkg.sv
`timescale 1ns/1ps
package olp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ON   = 3'd1,
      ST_OFF  = 3'd2,
      ST_HOT  = 3'd3,
      ST_HOLD = 3'd4
   } olp_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/olp_level_sync.sv
`timescale 1ns/1ps
module olp_level_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0) begin : g_bad
      $error("olp_level_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_flops
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else begin
            sh_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
               sh_q[i] <= sh_q[i-1];
            end
         end
      end
      assign q = sh_q[STAGES-1];
   end
endmodule

// File: rtl/olp_rise_strobe.sv
`timescale 1ns/1ps
module olp_rise_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic prev_q;
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         prev_q  <= d;
         pulse_q <= d & ~prev_q;
      end
   end

   assign q = pulse_q;

   // R10: a strobe never lasts more than one cycle
   a_r10_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
endmodule

// File: rtl/olp_tick_timer.sv
`timescale 1ns/1ps
module olp_tick_timer #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         done
);
   if (W < 1) begin : g_bad
      $error("olp_tick_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   assign done = run && tick && (cnt_q == limit - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (run && tick) begin
         cnt_q <= done ? '0 : cnt_q + W'(1);
      end
   end

   // R4: the tick count never passes the window being timed
   a_r4_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < limit));
endmodule

// File: rtl/olp_seq.sv
`timescale 1ns/1ps
module olp_seq #(
   parameter int ON_SHORT_MS = 90,
   parameter int ON_LONG_MS  = 180,
   parameter int OFF_MS      = 900,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_ms_i,
   input  logic ovl_i,
   input  logic ovt_i,
   input  logic vsel_nz_i,
   input  logic pulse_static_i,
   input  logic long_on_i,
   input  logic ovl_latch_i,
   input  logic thm_latch_i,
   output logic out_en_o,
   output logic vsel_clr_o,
   output logic ovl_set_o,
   output logic ovt_set_o
);
   import olp_pkg::*;

   localparam int MAX_MS = imax(imax(ON_SHORT_MS, ON_LONG_MS), OFF_MS);
   localparam int CNT_W  = $clog2(MAX_MS + 1);

   if (ON_SHORT_MS < 1 || ON_LONG_MS < 1 || OFF_MS < 1) begin : g_bad_len
      $error("olp_seq: every window must last at least one tick");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("olp_seq: SYNC_STAGES must not be negative");
   end

   // ---------------- input synchronisers (R11)
   logic ovl_s, ovt_s;

   olp_level_sync #(.STAGES(SYNC_STAGES)) u_sync_ovl (
      .clk(clk), .rst_n(rst_n), .d(ovl_i), .q(ovl_s));
   olp_level_sync #(.STAGES(SYNC_STAGES)) u_sync_ovt (
      .clk(clk), .rst_n(rst_n), .d(ovt_i), .q(ovt_s));

   // ---------------- sequencer state
   olp_state_e       st_q, st_d;
   logic             hit_q, hit_d;
   logic [CNT_W-1:0] on_len_q, on_len_d;
   logic             clr_d, clr_q;
   logic             tmr_run, tmr_clr, tmr_done;
   logic [CNT_W-1:0] tmr_limit;
   logic [CNT_W-1:0] on_pick;

   assign on_pick = long_on_i ? CNT_W'(ON_LONG_MS) : CNT_W'(ON_SHORT_MS);

   always_comb begin
      st_d     = st_q;
      hit_d    = hit_q;
      on_len_d = on_len_q;
      clr_d    = 1'b0;
      if (ovt_s) begin
         st_d = ST_HOT;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (ovl_s && vsel_nz_i && !pulse_static_i) begin
                  st_d     = ST_ON;
                  hit_d    = 1'b1;
                  on_len_d = on_pick;
               end
            end
            ST_ON: begin
               if (ovl_s) hit_d = 1'b1;
               if (tmr_done) begin
                  if (hit_q || ovl_s) begin
                     st_d = ST_OFF;
                  end else if (ovl_latch_i) begin
                     st_d  = ST_HOLD;
                     clr_d = 1'b1;
                  end else begin
                     st_d = ST_IDLE;
                  end
               end
            end
            ST_OFF: begin
               if (tmr_done) begin
                  st_d     = ST_ON;
                  hit_d    = 1'b0;
                  on_len_d = on_pick;
               end
            end
            ST_HOT: begin
               if (thm_latch_i) begin
                  st_d  = ST_HOLD;
                  clr_d = 1'b1;
               end else begin
                  st_d = ST_IDLE;
               end
            end
            ST_HOLD: begin
               if (!vsel_nz_i) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         hit_q    <= 1'b0;
         on_len_q <= CNT_W'(ON_SHORT_MS);
         clr_q    <= 1'b0;
      end else begin
         st_q     <= st_d;
         hit_q    <= hit_d;
         on_len_q <= on_len_d;
         clr_q    <= clr_d;
      end
   end

   // ---------------- window timer
   assign tmr_run   = (st_q == ST_ON) || (st_q == ST_OFF);
   assign tmr_clr   = (st_d != st_q);
   assign tmr_limit = (st_q == ST_OFF) ? CNT_W'(OFF_MS) : on_len_q;

   olp_tick_timer #(.W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
      .tick(tick_ms_i), .limit(tmr_limit), .done(tmr_done));

   // ---------------- outputs
   assign out_en_o   = ((st_q == ST_IDLE) || (st_q == ST_ON)) && vsel_nz_i;
   assign vsel_clr_o = clr_q;

   logic ovl_seen;
   assign ovl_seen = ovl_s && out_en_o;

   olp_rise_strobe u_ovl_strobe (
      .clk(clk), .rst_n(rst_n), .d(ovl_seen), .q(ovl_set_o));
   olp_rise_strobe u_ovt_strobe (
      .clk(clk), .rst_n(rst_n), .d(ovt_s), .q(ovt_set_o));

   // ---------------- assertions
   // R8: synchronised overtemperature always lands in the thermal state
   a_r8_ovt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovt_s |=> (st_q == ST_HOT));

   // R3: static mode never leaves idle because of overload
   a_r3_static_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && pulse_static_i && !ovt_s) |=> (st_q == ST_IDLE));

   // R4: the off window is left only when its timer expires
   a_r4_off_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OFF && !ovt_s && !tmr_done) |=> (st_q == ST_OFF));

   // R6: a clean window in self-resume mode goes back to idle
   a_r6_clean_window_resumes: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ON && tmr_done && !hit_q && !ovl_s && !ovt_s && !ovl_latch_i)
      |=> (st_q == ST_IDLE));

   // R7: the clear strobe is never seen with the output driven
   a_r7_clr_output_dark: assert property (@(posedge clk) disable iff (!rst_n)
      vsel_clr_o |-> !out_en_o);

   // R7: the clear strobe lasts one cycle
   a_r7_clr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      vsel_clr_o |=> !vsel_clr_o);
endmodule

// File: tb/olp_seq_tb.sv
`timescale 1ns/1ps
module olp_seq_tb;
   localparam int ON_S  = 6;
   localparam int ON_L  = 12;
   localparam int OFF_T = 30;
   localparam int DIV   = 4;

   typedef struct packed {
      logic       pcl;
      logic       tmr;
      logic       olr;
      logic [7:0] len;
      logic [3:0] offs;
      logic       fin;
      logic [1:0] clr;
   } vec_t;

   // static/dynamic, long window, latch recovery, burst ticks,
   // expected off windows, expected final enable, expected clear strobes
   localparam vec_t VECS [8] = '{
      '{1'b1, 1'b0, 1'b0, 8'd10, 4'd0, 1'b1, 2'd0},
      '{1'b0, 1'b0, 1'b0, 8'd3,  4'd1, 1'b1, 2'd0},
      '{1'b0, 1'b0, 1'b0, 8'd20, 4'd1, 1'b1, 2'd0},
      '{1'b0, 1'b0, 1'b0, 8'd40, 4'd2, 1'b1, 2'd0},
      '{1'b0, 1'b0, 1'b1, 8'd80, 4'd3, 1'b0, 2'd1},
      '{1'b0, 1'b1, 1'b0, 8'd30, 4'd1, 1'b1, 2'd0},
      '{1'b0, 1'b1, 1'b1, 8'd45, 4'd2, 1'b0, 2'd1},
      '{1'b1, 1'b0, 1'b1, 8'd10, 4'd0, 1'b1, 2'd0}
   };

   logic clk = 1'b0;
   logic rst_n, tick, ovl, ovt, vsel, pcl, tmr, olr, thm;
   logic out_en, vsel_clr, ovl_set, ovt_set;

   always #2.5 clk = ~clk;

   olp_seq #(.ON_SHORT_MS(ON_S), .ON_LONG_MS(ON_L), .OFF_MS(OFF_T), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_ms_i(tick), .ovl_i(ovl), .ovt_i(ovt),
      .vsel_nz_i(vsel), .pulse_static_i(pcl), .long_on_i(tmr),
      .ovl_latch_i(olr), .thm_latch_i(thm),
      .out_en_o(out_en), .vsel_clr_o(vsel_clr), .ovl_set_o(ovl_set), .ovt_set_o(ovt_set));

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // tick generator
   initial begin
      int dcnt;
      dcnt = 0;
      tick = 1'b0;
      forever begin
         @(negedge clk);
         dcnt = (dcnt + 1) % DIV;
         tick = (dcnt == 0);
      end
   end

   // output monitor: run lengths and strobe counts
   int   hi_runs [16];
   int   lo_runs [16];
   int   n_hi, n_lo, run_len, c_ovl, c_ovt, c_clr;
   logic prev_en;
   bit   mon_en = 0;

   always @(negedge clk) begin
      if (mon_en) begin
         if (out_en === prev_en) begin
            run_len++;
         end else begin
            if (prev_en === 1'b1) begin
               if (n_hi < 16) hi_runs[n_hi] = run_len;
               n_hi++;
            end else begin
               if (n_lo < 16) lo_runs[n_lo] = run_len;
               n_lo++;
            end
            run_len = 1;
            prev_en = out_en;
         end
         if (ovl_set === 1'b1)  c_ovl++;
         if (ovt_set === 1'b1)  c_ovt++;
         if (vsel_clr === 1'b1) c_clr++;
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic mon_start();
      n_hi = 0; n_lo = 0; run_len = 0;
      c_ovl = 0; c_ovt = 0; c_clr = 0;
      prev_en = out_en;
      mon_en = 1;
   endtask

   task automatic chk_eq(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
      total++;
      if (act < lo || act > hi) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      ovl = 1'b0;
      ovt = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ovl = 1'b0; ovt = 1'b0; vsel = 1'b0;
      pcl = 1'b0; tmr = 1'b0; olr = 1'b0; thm = 1'b0;

      // R1: reset state
      step(3);
      chk_eq("R1 out_en in reset", int'(out_en), 0);
      chk_eq("R1 strobes in reset", int'(vsel_clr | ovl_set | ovt_set), 0);
      rst_n = 1'b1;
      step(2);
      chk_eq("R1 out_en idle standby", int'(out_en), 0);
      vsel = 1'b1;
      step(1);
      chk_eq("R1 out_en follows select", int'(out_en), 1);

      // table of overload bursts: R3 R4 R5 R6 R7
      for (int i = 0; i < 8; i++) begin
         int on_t;
         vec_t v;
         v = VECS[i];
         do_reset();
         pcl = v.pcl; tmr = v.tmr; olr = v.olr; thm = 1'b0; vsel = 1'b1;
         on_t = v.tmr ? ON_L : ON_S;
         step(4);
         mon_start();
         ovl = 1'b1;
         step(int'(v.len) * DIV);
         ovl = 1'b0;
         step((int'(v.offs) * (on_t + OFF_T) + on_t + 4) * DIV);
         chk_eq($sformatf("R5 off window count vec%0d", i), n_lo, int'(v.offs));
         chk_eq($sformatf("R6 final enable vec%0d", i), int'(out_en), int'(v.fin));
         chk_eq($sformatf("R7 clear strobes vec%0d", i), c_clr, int'(v.clr));
         if (v.pcl) begin
            chk_eq($sformatf("R3 static overload strobes vec%0d", i), c_ovl, 1);
         end else begin
            chk_rng($sformatf("R4 first on window vec%0d", i), hi_runs[0],
                    (on_t - 1) * DIV, (on_t + 1) * DIV + 4);
            for (int k = 0; k < int'(v.offs) && k < n_lo; k++)
               chk_eq($sformatf("R4 off length vec%0d win%0d", i, k), lo_runs[k], OFF_T * DIV);
            if (v.offs >= 2)
               chk_eq($sformatf("R5 repeat on window vec%0d", i), hi_runs[1], on_t * DIV);
         end
         if (v.clr != 0) begin
            step(20);
            chk_eq($sformatf("R7 output held vec%0d", i), int'(out_en), 0);
            vsel = 1'b0;
            step(3);
            vsel = 1'b1;
            step(2);
            chk_eq($sformatf("R7 output after rewrite vec%0d", i), int'(out_en), 1);
         end
         mon_en = 0;
      end

      // R2: standby ignores overload
      do_reset();
      pcl = 1'b0; tmr = 1'b0; olr = 1'b0; thm = 1'b0; vsel = 1'b0;
      step(4);
      mon_start();
      ovl = 1'b1;
      step(60 * DIV);
      chk_eq("R2 standby output low", int'(out_en), 0);
      chk_eq("R2 standby no overload strobe", c_ovl, 0);
      ovl = 1'b0;
      step(3);
      vsel = 1'b1;
      step(1);
      chk_eq("R2 enable after standby", int'(out_en), 1);
      mon_en = 0;

      // R10: one strobe per overload edge while enabled
      do_reset();
      pcl = 1'b1; vsel = 1'b1;
      step(4);
      mon_start();
      ovl = 1'b1; step(10); ovl = 1'b0; step(10);
      ovl = 1'b1; step(10); ovl = 1'b0; step(5);
      chk_eq("R10 overload strobe count", c_ovl, 2);
      chk_eq("R3 static output kept", int'(out_en), 1);
      mon_en = 0;

      // R11 R8 R9: thermal with self-resume
      do_reset();
      pcl = 1'b0; thm = 1'b0; vsel = 1'b1;
      step(4);
      mon_start();
      ovt = 1'b1;
      step(2);
      chk_eq("R11 still enabled two edges after", int'(out_en), 1);
      step(1);
      chk_eq("R11 disabled after third edge", int'(out_en), 0);
      ovl = 1'b1;
      step(100);
      chk_eq("R8 overtemperature keeps output low", int'(out_en), 0);
      chk_eq("R8 one thermal strobe", c_ovt, 1);
      ovl = 1'b0;
      step(5);
      ovt = 1'b0;
      step(5);
      chk_eq("R9 self-resume after thermal", int'(out_en), 1);
      chk_eq("R9 no clear in self-resume", c_clr, 0);

      // R9: thermal with latch recovery
      thm = 1'b1;
      mon_start();
      ovt = 1'b1; step(10); ovt = 1'b0; step(10);
      chk_eq("R9 latch holds output low", int'(out_en), 0);
      chk_eq("R9 latch clear strobe", c_clr, 1);
      vsel = 1'b0; step(3); vsel = 1'b1; step(2);
      chk_eq("R9 enable after rewrite", int'(out_en), 1);
      mon_en = 0;

      // R8: thermal in an off window discards the overload timers
      do_reset();
      pcl = 1'b0; tmr = 1'b0; olr = 1'b0; thm = 1'b0; vsel = 1'b1;
      step(4);
      ovl = 1'b1;
      step((ON_S + 5) * DIV);
      chk_eq("R4 inside off window", int'(out_en), 0);
      ovt = 1'b1; step(10);
      ovl = 1'b0; step(5);
      ovt = 1'b0; step(5);
      chk_eq("R8 timers discarded on thermal", int'(out_en), 1);
      mon_start();
      step(50 * DIV);
      chk_eq("R8 no later off window", n_lo, 0);
      mon_en = 0;

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule